// File: doc/BRIEF.md
# Write-Only Two-Wire Register Slave

This block is a receive-only slave for a two-wire serial bus (I2C). It lives on a fast system clock and oversamples the bus clock and data lines. The lines pass through a two-flop synchronizer and a majority-free run-length glitch filter. Bus events are then detected from the filtered levels: a start, a stop, a rising clock and a falling clock. A controller state machine takes these events and receives an address byte, a subaddress byte and any number of data bytes. Each data byte lands in one of nine 8-bit control registers, and all nine registers are driven out in parallel.

The device address is 7 bits. Six of the bits are fixed and one comes from a strap input, so two of these slaves can share a bus. The slave never returns data. It pulls SDA low only during acknowledge bits, through an active-low open-drain enable. After each data byte the subaddress moves up by one and holds at the last register. Software can turn this stepping off with a bit inside the register bank, so that repeated bytes keep rewriting one register.

The states of the controller are:
- IDLE: ignores the bus.
- ADDR: shifting the address byte.
- ADDR_ACK: driving the address acknowledge.
- SUB: shifting the subaddress.
- SUB_ACK: acknowledging the subaddress.
- DATA: shifting a data byte.
- DATA_ACK: acknowledging the data byte.

The transitions are:
- A stop sends any state to IDLE.
- A start sends any state to ADDR.
- ADDR goes to ADDR_ACK on a matching write address and to IDLE otherwise. This happens at the falling clock after the 8th bit.
- The three receive states leave on the falling clock after their 8th bit. The three acknowledge states leave on the falling clock that ends the 9th bit.
- ADDR_ACK goes to SUB, SUB goes to SUB_ACK, SUB_ACK goes to DATA, DATA goes to DATA_ACK, and DATA_ACK goes back to DATA.

Top module: `i2cw_slave_top`

## Requirements
- R1: While reset is asserted and right after it, every register output reads 00h and `sda_pull_o` is 0 (SDA released). A 0 in the step-disable bit means stepping is on.
- R2: A stop (SDA rising while SCL is high) ends capture. Bytes clocked after a stop without a new start get no acknowledge and change no register.
- R3: An address byte equal to {1,0,0,0,1,`addr_sel_i`,0} followed by R/W = 0 (bit 0 of the byte) is acknowledged. The acknowledge is SDA held low for the 9th clock.
- R4: Any other address byte, including the matching address with R/W = 1, leaves SDA released. The bus is then ignored until the next start.
- R5: Bytes arrive MSB first. The byte after the address selects the subaddress and is always acknowledged. Each following data byte is acknowledged and written to the register at the current subaddress (00h..08h).
- R6: With stepping on, the subaddress increases by one after each data byte. Once it is 08h it stays there, so further bytes overwrite register 08h.
- R7: Bit `AINC_BIT` of register `AINC_REG` is a step-disable bit. When it is 1, all data bytes of a transfer rewrite the same register.
- R8: A write to the step-disable bit decides stepping only from the next data byte on. The byte that carries it steps according to the previous value.
- R9: A subaddress above 08h is acknowledged. Data bytes sent to it are acknowledged but change no register.
- R10: A repeated start in the middle of a transfer restarts address matching. A following matching address, subaddress and data write normally. A following non-matching address is ignored.
- R11: `sda_pull_o` changes only while the filtered SCL is low. It is never 1 while a data bit of any byte is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level as seen at the pad |
| sda_i | input | 1 | Bus data level as seen at the pad |
| addr_sel_i | input | 1 | Strap giving device address bit 1 |
| sda_pull_o | output | 1 | Open-drain enable, 1 pulls SDA low |
| regs_o | output | NUM_REGS*DATA_W | All registers, register k at bits k*8 +: 8 |

## Verification
The bench keeps nine registers but moves the step-disable bit to bit 0 of register 01h. In that position a burst can pass through the bit and step beyond it. This brings the next-byte rule of R8 within reach, which the default position at register 08h would hide behind saturation. SCL runs at one thirty-second of the system clock. The bench sweeps all 128 addresses with the strap low, so every address bit is seen to matter. Every transfer is compared against a register model the bench keeps from the requirements.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK
    } st_e;

    // Fixed upper part of the device address; bit 1 is strapped, bit 0 fixed 0
    localparam logic [4:0] DEV_ADDR_HI = 5'b10001;
    localparam logic       DEV_ADDR_B0 = 1'b0;
    localparam logic       RW_WRITE    = 1'b0;

endpackage

// File: rtl/i2cw_deglitch.sv
module i2cw_deglitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    // Two-flop synchronizer, then a level is taken only after FILT_LEN equal samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            hist_q  <= '1;
            clean_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                clean_o <= 1'b1;
            else if (~|hist_q)
                clean_o <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_f;
            sda_p_q <= sda_f;
        end
    end

    assign start_evt = scl_f && scl_p_q && sda_p_q && !sda_f;
    assign stop_evt  = scl_f && scl_p_q && !sda_p_q && sda_f;
    assign scl_rise  = scl_f && !scl_p_q;
    assign scl_fall  = !scl_f && scl_p_q;
endmodule

// File: rtl/i2cw_fsm.sv
module i2cw_fsm
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS = 9,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_f,
    input  logic             addr_sel,
    input  logic             ainc_en,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_pull,
    output st_e              state_q,
    output logic [7:0]       sub_q
);
    localparam logic [7:0] LAST_SUB = 8'(NUM_REGS - 1);

    st_e        state_d;
    logic [7:0] shift_q;
    logic [3:0] bitcnt_q;
    logic       byte_done;
    logic       addr_hit;
    logic       rx_state;

    assign byte_done = scl_fall && (bitcnt_q == 4'd8);
    assign addr_hit  = (shift_q == {DEV_ADDR_HI, addr_sel, DEV_ADDR_B0, RW_WRITE});
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_DATA);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall)  state_d = ST_SUB;
                ST_SUB:      if (byte_done) state_d = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall)  state_d = ST_DATA;
                ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_d = ST_DATA;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= '0;
            bitcnt_q <= '0;
            sub_q    <= '0;
            sda_pull <= 1'b0;
        end else begin
            sda_pull <= (state_d == ST_ADDR_ACK) || (state_d == ST_SUB_ACK) ||
                        (state_d == ST_DATA_ACK);

            if (start_evt || stop_evt) begin
                bitcnt_q <= '0;
            end else if (rx_state && scl_rise) begin
                shift_q  <= {shift_q[6:0], sda_f};
                bitcnt_q <= bitcnt_q + 4'd1;
            end else if (!rx_state && scl_fall) begin
                bitcnt_q <= '0;
            end

            if (state_q == ST_SUB && byte_done)
                sub_q <= shift_q;
            else if (state_q == ST_DATA && byte_done && ainc_en && sub_q < LAST_SUB)
                sub_q <= sub_q + 8'd1;
        end
    end

    assign wr_en   = (state_q == ST_DATA) && byte_done && (sub_q <= LAST_SUB);
    assign wr_idx  = sub_q[IDX_W-1:0];
    assign wr_data = shift_q;
endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile #(
    parameter int NUM_REGS = 9,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 4,
    parameter int AINC_REG = 8,
    parameter int AINC_BIT = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic                       ainc_en
);
    logic [DATA_W-1:0] mem_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                mem_q[g] <= wr_data;
        end
        assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];
    end

    // Stored bit is a disable, so an all-zero reset leaves stepping on
    assign ainc_en = ~mem_q[AINC_REG][AINC_BIT];
endmodule

// File: rtl/i2cw_slave_top.sv
module i2cw_slave_top
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS = 9,
    parameter int DATA_W   = 8,
    parameter int FILT_LEN = 3,
    parameter int AINC_REG = 8,
    parameter int AINC_BIT = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    input  logic                       addr_sel_i,
    output logic                       sda_pull_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic             scl_f, sda_f;
    logic             start_evt, stop_evt, scl_rise, scl_fall;
    logic             wr_en, ainc_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [7:0]       sub_q;
    st_e              state_q;

    i2cw_deglitch #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f)
    );

    i2cw_deglitch #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f)
    );

    i2cw_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    i2cw_fsm #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_f(sda_f),
        .addr_sel(addr_sel_i), .ainc_en(ainc_en),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data[7:0]),
        .sda_pull(sda_pull_o), .state_q(state_q), .sub_q(sub_q)
    );

    i2cw_regfile #(
        .NUM_REGS(NUM_REGS), .DATA_W(8), .IDX_W(IDX_W),
        .AINC_REG(AINC_REG), .AINC_BIT(AINC_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_o(regs_o), .ainc_en(ainc_en)
    );
endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS = 9,
    parameter int IDX_W    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             start_evt,
    input logic             stop_evt,
    input st_e              state_q,
    input logic             sda_pull_o,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [7:0]       sub_q
);
    localparam logic [7:0] LAST_SUB = 8'(NUM_REGS - 1);

    // R1
    always @(posedge clk) begin
        if (!rst_n)
            reset_released_chk: assert (!sda_pull_o);
    end

    // R11
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !$past(scl_f));

    // R2
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> state_q == ST_IDLE);

    // R10
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt && !stop_evt |=> state_q == ST_ADDR);

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !sda_pull_o);

    // R9
    write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> 32'(wr_idx) < NUM_REGS);

    // R6
    sub_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && sub_q == LAST_SUB |=> sub_q == LAST_SUB);
endmodule

bind i2cw_slave_top i2cw_slave_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_evt(start_evt),
    .stop_evt(stop_evt), .state_q(state_q), .sda_pull_o(sda_pull_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .sub_q(sub_q)
);

// File: tb/i2cw_slave_top_tb_top.sv
`timescale 1ns/1ps
module i2cw_slave_top_tb_top;
    localparam int NR   = 9;
    localparam int AREG = 1;
    localparam int ABIT = 0;
    localparam int Q    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          addr_sel = 1'b0;
    logic          sda_pull;
    logic [NR*8-1:0] regs;
    logic          sda_line;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] model [NR];

    assign sda_line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    i2cw_slave_top #(.NUM_REGS(NR), .DATA_W(8), .FILT_LEN(3),
                     .AINC_REG(AREG), .AINC_BIT(ABIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_sel_i(addr_sel), .sda_pull_o(sda_pull), .regs_o(regs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    // Shifts one byte MSB first; returns ack and whether the slave pulled during data bits
    task automatic put_byte(input logic [7:0] b, output logic ack, output logic pulled);
        pulled = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl = 1'b1; wq(Q);
            if (sda_pull) pulled = 1'b1;
            wq(Q); scl = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic send(input logic [7:0] b, input logic exp_ack, input string req);
        logic a, p;
        put_byte(b, a, p);
        chk(req, {31'd0, a}, {31'd0, exp_ack});
        chk("R11", {31'd0, p}, 32'd0);
    endtask

    function automatic logic [7:0] adr(input logic sel);
        return {5'b10001, sel, 1'b0, 1'b0};
    endfunction

    task automatic cmp_all(input string req);
        for (int i = 0; i < NR; i++)
            chk(req, {24'd0, regs[i*8 +: 8]}, {24'd0, model[i]});
    endtask

    // Full write transfer; model follows R5..R9
    task automatic xfer(input logic [7:0] sub, input logic [7:0] d [], input string req);
        int s;
        logic dis;
        bus_start();
        send(adr(addr_sel), 1'b1, req);
        send(sub, 1'b1, req);
        s = sub;
        foreach (d[k]) begin
            send(d[k], 1'b1, req);
            dis = model[AREG][ABIT];
            if (s < NR) model[s] = d[k];
            if (!dis && s < NR - 1) s++;
        end
        bus_stop();
        wq(4);
        cmp_all(req);
    endtask

    initial begin
        logic [7:0] d [];
        for (int i = 0; i < NR; i++) model[i] = 8'h00;
        wq(3);
        // R1: outputs during reset
        chk("R1", {31'd0, sda_pull}, 32'd0);
        cmp_all("R1");
        rst_n = 1'b1;
        wq(4);
        chk("R1", {31'd0, sda_pull}, 32'd0);
        cmp_all("R1");

        // R3 / R4: sweep all 7-bit addresses, strap low
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send({7'(a), 1'b0}, (a == 7'h44), (a == 7'h44) ? "R3" : "R4");
            bus_stop();
        end
        // R4: read direction refused
        bus_start(); send({7'h44, 1'b1}, 1'b0, "R4"); bus_stop();
        // R4: bytes after a refused address are ignored
        bus_start();
        send(8'h8E, 1'b0, "R4");
        send(8'h00, 1'b0, "R4");
        send(8'h55, 1'b0, "R4");
        bus_stop(); wq(4);
        cmp_all("R4");

        // R5: single write to every register
        for (int i = 0; i < NR; i++) begin
            d = new[1];
            d[0] = 8'((i * 37 + 8'h12) & 8'hFE);
            xfer(8'(i), d, "R5");
        end

        // R6: burst that reaches and holds at the last register
        d = new[7];
        foreach (d[k]) d[k] = 8'((k * 34 + 8'h40) & 8'hFE);
        xfer(8'h05, d, "R6");
        d = new[9];
        foreach (d[k]) d[k] = 8'((k * 50 + 8'h0A) & 8'hFE);
        xfer(8'h00, d, "R6");

        // R7: disable stepping, burst rewrites one register
        d = new[1]; d[0] = 8'h01;
        xfer(8'h01, d, "R7");
        d = new[3]; d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
        xfer(8'h03, d, "R7");

        // R8: enable written while disabled takes effect one byte later
        d = new[3]; d[0] = 8'h00; d[1] = 8'hA4; d[2] = 8'hB6;
        xfer(8'h01, d, "R8");
        // R8: disable written while enabled still steps once
        d = new[4]; d[0] = 8'h10; d[1] = 8'h03; d[2] = 8'h20; d[3] = 8'h30;
        xfer(8'h00, d, "R8");
        d = new[1]; d[0] = 8'h00;
        xfer(8'h01, d, "R8");

        // R9: out-of-range subaddresses
        d = new[2]; d[0] = 8'h77; d[1] = 8'h78;
        xfer(8'h0C, d, "R9");
        xfer(8'hFF, d, "R9");

        // R10: repeated start to a new subaddress
        bus_start();
        send(adr(1'b0), 1'b1, "R10"); send(8'h02, 1'b1, "R10"); send(8'h5A, 1'b1, "R10");
        model[2] = 8'h5A;
        bus_start();
        send(adr(1'b0), 1'b1, "R10"); send(8'h06, 1'b1, "R10"); send(8'h6C, 1'b1, "R10");
        model[6] = 8'h6C;
        // R10: repeated start with foreign address, rest ignored
        bus_start();
        send(8'h90, 1'b0, "R10"); send(8'h03, 1'b0, "R10"); send(8'hEE, 1'b0, "R10");
        bus_stop(); wq(4);
        cmp_all("R10");

        // R2: bytes after stop without start
        send(adr(1'b0), 1'b0, "R2");
        send(8'h04, 1'b0, "R2");
        send(8'hC3, 1'b0, "R2");
        wq(4);
        cmp_all("R2");

        // R3: strap high moves the address
        addr_sel = 1'b1;
        bus_start(); send(adr(1'b0), 1'b0, "R3"); bus_stop();
        d = new[1]; d[0] = 8'h98;
        xfer(8'h07, d, "R3");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule